// File: doc/BRIEF.md
# Receive Error Status and Forwarding Filter

This block sits at the end of a receive path. For every completion descriptor it builds the error and checksum-status field, and for the final descriptor of a frame it decides whether the frame goes to the host. The upstream logic supplies, with each descriptor strobe, four things: the line-level error flags seen during the frame, the checksum results together with flags saying whether each checksum was computed, the frame's type/length value and its measured L2 payload size, and the configuration bits. The configuration bits are store-bad-frames, forward-length-errors, IP checksum offload enable and L4 checksum offload enable.

The result is registered. One cycle after the descriptor strobe the block presents a one-cycle done pulse, an end-of-packet flag, a 10-bit error field and a forward flag. Only the descriptor that closes a frame carries error bits or a forwarding decision. The descriptors of a frame's earlier buffers come out with a clean field.

Top module: `rx_err_filter`

## Requirements
- R1: A cycle with `desc_vld` high produces `desc_done` high in the next cycle, with `desc_eop` equal to the `desc_last` value sampled with it. A cycle without `desc_vld` produces no `desc_done` in the next cycle. After reset all outputs are 0.
- R2: A descriptor with `desc_last` low produces an all-zero `desc_err`, a low `desc_phy_err` and a low `fwd_frame`, whatever its error inputs.
- R3: `desc_err` bits 8, 2, 1 and 0 are always 0.
- R4: `desc_err` bit 9 (L4 checksum error) is 1 only when `cfg_l4_offload`, `l4_csum_done` and `l4_csum_bad` are all 1.
- R5: `desc_err` bit 6 (IP checksum error) is 1 only when `cfg_ip_offload`, `ip_csum_done` and `ip_csum_bad` are all 1.
- R6: CRC errors and alignment errors share `desc_err` bit 4. Bit 4, symbol-error bit 5 and the `desc_phy_err` output are reported only when `cfg_store_bad` is 1.
- R7: A closing descriptor with any of `crc_err`, `align_err`, `phy_err` or `sym_err` set gives `fwd_frame` = 0 unless `cfg_store_bad` is 1.
- R8: `desc_err` bit 7 (length error) is 1 exactly when `crc_err` and `align_err` are 0, `type_len` <= 1500 and `type_len` > `l2_payload_len`.
- R9: A frame with a length error gives `fwd_frame` = 1 only if `cfg_fwd_len_err` or `cfg_store_bad` is 1.
- R10: The checksum error inputs never change `fwd_frame`.
- R11: `desc_err` bit 3 (header buffer overflow) copies `hdr_ovf` on a closing descriptor.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| desc_vld | input | 1 | Descriptor completion strobe |
| desc_last | input | 1 | This descriptor closes the frame |
| phy_err | input | 1 | PHY data error seen during the frame |
| sym_err | input | 1 | Symbol error seen during the frame |
| crc_err | input | 1 | Frame check sequence mismatch |
| align_err | input | 1 | Alignment error |
| ip_csum_done | input | 1 | IP header checksum was computed |
| ip_csum_bad | input | 1 | IP header checksum mismatch |
| l4_csum_done | input | 1 | TCP/UDP checksum was computed |
| l4_csum_bad | input | 1 | TCP/UDP checksum mismatch |
| hdr_ovf | input | 1 | Header larger than the header buffer |
| type_len | input | 16 | Type/length field of the frame |
| l2_payload_len | input | 16 | Measured L2 payload byte count |
| cfg_store_bad | input | 1 | Deliver bad frames with their error bits |
| cfg_fwd_len_err | input | 1 | Deliver frames with length errors |
| cfg_ip_offload | input | 1 | IP checksum offload enabled |
| cfg_l4_offload | input | 1 | L4 checksum offload enabled |
| desc_done | output | 1 | One-cycle descriptor done pulse |
| desc_eop | output | 1 | End of packet flag |
| desc_err | output | 10 | Error field |
| desc_phy_err | output | 1 | PHY data error report |
| fwd_frame | output | 1 | Frame is delivered to the host |

## Verification
The hardest case to reach is a frame whose buffers do not all close it. Error inputs present on an early buffer must vanish from that descriptor, and the same inputs must then appear on the closing descriptor. The bench sends a non-closing descriptor with every error input raised, then a closing one with the same inputs. A second hard corner is the length comparison at its edges: 1500 against 1501, and an equal payload. These are combined with a CRC error that must mask the length error.

// File: rtl/rx_err_pkg.sv
package rx_err_pkg;
  localparam int unsigned ERR_W     = 10;
  localparam int unsigned BIT_L4    = 9;
  localparam int unsigned BIT_LEN   = 7;
  localparam int unsigned BIT_IP    = 6;
  localparam int unsigned BIT_SYM   = 5;
  localparam int unsigned BIT_CRC   = 4;
  localparam int unsigned BIT_HOVF  = 3;

  typedef struct packed {
    logic phy;
    logic sym;
    logic crc;
    logic align;
  } line_err_t;

  typedef struct packed {
    logic ip_done;
    logic ip_bad;
    logic l4_done;
    logic l4_bad;
  } csum_t;

  typedef struct packed {
    logic store_bad;
    logic fwd_len;
    logic ip_en;
    logic l4_en;
  } cfg_t;
endpackage

// File: rtl/rx_err_lenchk.sv
module rx_err_lenchk #(
  parameter int unsigned LEN_W  = 16,
  parameter int unsigned MAX_TL = 1500
) (
  input  logic [LEN_W-1:0] type_len,
  input  logic [LEN_W-1:0] payload_len,
  input  logic             fcs_bad,
  output logic             len_err
);
  localparam logic [LEN_W-1:0] TL_LIMIT = LEN_W'(MAX_TL);

  logic is_length;
  logic too_short;

  always_comb begin
    is_length = (type_len <= TL_LIMIT);
    too_short = (type_len > payload_len);
    len_err   = is_length && too_short && !fcs_bad;
  end
endmodule

// File: rtl/rx_err_classify.sv
module rx_err_classify
  import rx_err_pkg::*;
(
  input  line_err_t        lerr,
  input  csum_t            csum,
  input  cfg_t             cfg,
  input  logic             hdr_ovf,
  input  logic             len_err,
  input  logic             last,
  output logic [ERR_W-1:0] err_field,
  output logic             phy_rep,
  output logic             fwd
);
  logic fcs_bad;
  logic line_bad;
  logic drop_line;
  logic drop_len;

  always_comb begin
    fcs_bad   = lerr.crc | lerr.align;
    line_bad  = fcs_bad | lerr.phy | lerr.sym;
    drop_line = line_bad & ~cfg.store_bad;
    drop_len  = len_err & ~(cfg.fwd_len | cfg.store_bad);

    err_field = '0;
    phy_rep   = 1'b0;
    fwd       = 1'b0;
    if (last) begin
      err_field[BIT_L4]   = cfg.l4_en & csum.l4_done & csum.l4_bad;
      err_field[BIT_IP]   = cfg.ip_en & csum.ip_done & csum.ip_bad;
      err_field[BIT_LEN]  = len_err;
      err_field[BIT_SYM]  = lerr.sym & cfg.store_bad;
      err_field[BIT_CRC]  = fcs_bad & cfg.store_bad;
      err_field[BIT_HOVF] = hdr_ovf;
      phy_rep             = lerr.phy & cfg.store_bad;
      fwd                 = ~(drop_line | drop_len);
    end
  end
endmodule

// File: rtl/rx_err_filter.sv
module rx_err_filter
  import rx_err_pkg::*;
#(
  parameter int unsigned LEN_W  = 16,
  parameter int unsigned MAX_TL = 1500
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             desc_vld,
  input  logic             desc_last,
  input  logic             phy_err,
  input  logic             sym_err,
  input  logic             crc_err,
  input  logic             align_err,
  input  logic             ip_csum_done,
  input  logic             ip_csum_bad,
  input  logic             l4_csum_done,
  input  logic             l4_csum_bad,
  input  logic             hdr_ovf,
  input  logic [LEN_W-1:0] type_len,
  input  logic [LEN_W-1:0] l2_payload_len,
  input  logic             cfg_store_bad,
  input  logic             cfg_fwd_len_err,
  input  logic             cfg_ip_offload,
  input  logic             cfg_l4_offload,
  output logic             desc_done,
  output logic             desc_eop,
  output logic [ERR_W-1:0] desc_err,
  output logic             desc_phy_err,
  output logic             fwd_frame
);
  line_err_t        lerr;
  csum_t            csum;
  cfg_t             cfg;
  logic             len_err;
  logic [ERR_W-1:0] err_nxt;
  logic             phy_nxt;
  logic             fwd_nxt;
  logic             eop_nxt;
  logic             done_nxt;
  logic             load_en;

  always_comb begin
    lerr = '{phy: phy_err, sym: sym_err, crc: crc_err, align: align_err};
    csum = '{ip_done: ip_csum_done, ip_bad: ip_csum_bad,
             l4_done: l4_csum_done, l4_bad: l4_csum_bad};
    cfg  = '{store_bad: cfg_store_bad, fwd_len: cfg_fwd_len_err,
             ip_en: cfg_ip_offload, l4_en: cfg_l4_offload};
  end

  rx_err_lenchk #(.LEN_W(LEN_W), .MAX_TL(MAX_TL)) u_lenchk (
    .type_len    (type_len),
    .payload_len (l2_payload_len),
    .fcs_bad     (crc_err | align_err),
    .len_err     (len_err)
  );

  rx_err_classify u_class (
    .lerr      (lerr),
    .csum      (csum),
    .cfg       (cfg),
    .hdr_ovf   (hdr_ovf),
    .len_err   (len_err),
    .last      (desc_last),
    .err_field (err_nxt),
    .phy_rep   (phy_nxt),
    .fwd       (fwd_nxt)
  );

  always_comb begin
    load_en  = desc_vld;
    done_nxt = desc_vld;
    eop_nxt  = desc_last;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      desc_done <= 1'b0;
    end else begin
      desc_done <= done_nxt;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      desc_eop     <= 1'b0;
      desc_err     <= '0;
      desc_phy_err <= 1'b0;
      fwd_frame    <= 1'b0;
    end else if (load_en) begin
      desc_eop     <= eop_nxt;
      desc_err     <= err_nxt;
      desc_phy_err <= phy_nxt;
      fwd_frame    <= fwd_nxt;
    end
  end
endmodule

// File: rtl/rx_err_filter_chk.sv
module rx_err_filter_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       desc_vld,
  input logic       desc_last,
  input logic       cfg_store_bad,
  input logic       cfg_l4_offload,
  input logic       desc_done,
  input logic       desc_eop,
  input logic [9:0] desc_err,
  input logic       fwd_frame
);
  // R1
  done_follows_vld_chk: assert property (@(posedge clk) disable iff (!rst_n)
    desc_vld |=> desc_done);
  // R1
  no_spurious_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !desc_vld |=> !desc_done);
  // R2
  early_buf_clean_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (desc_done && !desc_eop) |-> (desc_err == 10'd0 && !fwd_frame));
  // R3
  reserved_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    desc_done |-> (desc_err[8] == 1'b0 && desc_err[2:0] == 3'b000));
  // R4
  l4_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (desc_vld && !cfg_l4_offload) |=> !desc_err[9]);
  // R6
  crc_hidden_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (desc_vld && !cfg_store_bad) |=> (!desc_err[4] && !desc_err[5]));
  // R7
  store_bad_fwd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (desc_vld && desc_last && cfg_store_bad) |=> fwd_frame);
endmodule

bind rx_err_filter rx_err_filter_chk chk_i (.*);

// File: tb/rx_err_filter_tb_top.sv
module rx_err_filter_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 20000;

  logic clk;
  logic rst_n;
  logic desc_vld, desc_last;
  logic phy_err, sym_err, crc_err, align_err;
  logic ip_csum_done, ip_csum_bad, l4_csum_done, l4_csum_bad;
  logic hdr_ovf;
  logic [15:0] type_len, l2_payload_len;
  logic cfg_store_bad, cfg_fwd_len_err, cfg_ip_offload, cfg_l4_offload;
  logic desc_done, desc_eop, desc_phy_err, fwd_frame;
  logic [9:0] desc_err;

  int n_chk;
  int n_bad;

  rx_err_filter dut_i (
    .clk(clk), .rst_n(rst_n), .desc_vld(desc_vld), .desc_last(desc_last),
    .phy_err(phy_err), .sym_err(sym_err), .crc_err(crc_err), .align_err(align_err),
    .ip_csum_done(ip_csum_done), .ip_csum_bad(ip_csum_bad),
    .l4_csum_done(l4_csum_done), .l4_csum_bad(l4_csum_bad),
    .hdr_ovf(hdr_ovf), .type_len(type_len), .l2_payload_len(l2_payload_len),
    .cfg_store_bad(cfg_store_bad), .cfg_fwd_len_err(cfg_fwd_len_err),
    .cfg_ip_offload(cfg_ip_offload), .cfg_l4_offload(cfg_l4_offload),
    .desc_done(desc_done), .desc_eop(desc_eop), .desc_err(desc_err),
    .desc_phy_err(desc_phy_err), .fwd_frame(fwd_frame)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual=hung expected=finished");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  task automatic check(input string tag, input logic [13:0] act, input logic [13:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic clear_in();
    desc_vld = 0; desc_last = 1;
    phy_err = 0; sym_err = 0; crc_err = 0; align_err = 0;
    ip_csum_done = 0; ip_csum_bad = 0; l4_csum_done = 0; l4_csum_bad = 0;
    hdr_ovf = 0; type_len = 16'h0800; l2_payload_len = 16'd100;
    cfg_store_bad = 0; cfg_fwd_len_err = 0; cfg_ip_offload = 1; cfg_l4_offload = 1;
  endtask

  // Model written from the requirements: {done, eop, phy, fwd, err[9:0]}
  function automatic logic [13:0] model();
    logic [9:0] e;
    logic fcs, lenbad, linebad, fwd, phy;
    e = '0; fwd = 0; phy = 0;
    fcs = crc_err | align_err;
    lenbad = !fcs && (type_len <= 16'd1500) && (type_len > l2_payload_len);
    linebad = fcs | phy_err | sym_err;
    if (desc_last) begin
      e[9] = cfg_l4_offload & l4_csum_done & l4_csum_bad;
      e[7] = lenbad;
      e[6] = cfg_ip_offload & ip_csum_done & ip_csum_bad;
      e[5] = sym_err & cfg_store_bad;
      e[4] = fcs & cfg_store_bad;
      e[3] = hdr_ovf;
      phy  = phy_err & cfg_store_bad;
      fwd  = !(linebad && !cfg_store_bad) && !(lenbad && !(cfg_fwd_len_err || cfg_store_bad));
    end
    return {1'b1, desc_last, phy, fwd, e};
  endfunction

  // drive one descriptor, check outputs one cycle later
  task automatic send(input string tag);
    logic [13:0] exp;
    @(negedge clk);
    desc_vld = 1;
    exp = model();
    @(negedge clk);
    desc_vld = 0;
    check(tag, {desc_done, desc_eop, desc_phy_err, fwd_frame, desc_err}, exp);
  endtask

  task automatic t_reset();
    check("R1 reset", {desc_done, desc_eop, desc_phy_err, fwd_frame, desc_err}, 14'h0);
  endtask

  task automatic t_clean_and_idle();
    clear_in();
    send("R1 clean frame");
    @(negedge clk);
    check("R1 no strobe no done", {13'h0, desc_done}, 14'h0);
  endtask

  task automatic t_l4();
    clear_in(); l4_csum_done = 1; l4_csum_bad = 1;
    send("R4 l4 bad reported");
    cfg_l4_offload = 0;
    send("R4 l4 offload off");
    cfg_l4_offload = 1; l4_csum_done = 0;
    send("R4 l4 not computed");
  endtask

  task automatic t_ip();
    clear_in(); ip_csum_done = 1; ip_csum_bad = 1;
    send("R5 ip bad reported, R10 still forwarded");
    cfg_ip_offload = 0;
    send("R5 ip offload off");
  endtask

  task automatic t_crc();
    clear_in(); crc_err = 1;
    send("R7 crc dropped, R6 hidden");
    cfg_store_bad = 1;
    send("R6 crc shown with store-bad");
    crc_err = 0; align_err = 1;
    send("R6 align shares crc bit");
    align_err = 0; phy_err = 1; sym_err = 1;
    send("R6 phy and symbol shown");
    cfg_store_bad = 0;
    send("R7 phy and symbol dropped");
  endtask

  task automatic t_len();
    clear_in(); type_len = 16'd100; l2_payload_len = 16'd46;
    send("R8 R9 length error dropped");
    type_len = 16'd46;
    send("R8 equal length no error");
    type_len = 16'd1500; l2_payload_len = 16'd1000;
    send("R8 1500 is length");
    type_len = 16'd1501;
    send("R8 1501 is type");
    type_len = 16'd1500; crc_err = 1; cfg_store_bad = 1;
    send("R8 crc masks length error");
    crc_err = 0; cfg_store_bad = 0; cfg_fwd_len_err = 1;
    send("R9 forward length errors");
    cfg_fwd_len_err = 0; cfg_store_bad = 1;
    send("R9 store-bad forwards length errors");
  endtask

  task automatic t_multi();
    clear_in();
    desc_last = 0; crc_err = 1; phy_err = 1; sym_err = 1; hdr_ovf = 1;
    l4_csum_done = 1; l4_csum_bad = 1; cfg_store_bad = 1;
    type_len = 16'd200; l2_payload_len = 16'd10;
    send("R2 early buffer clean");
    desc_last = 1;
    send("R2 closing buffer carries errors, R3 reserved");
  endtask

  task automatic t_hovf();
    clear_in(); hdr_ovf = 1;
    send("R11 header overflow bit");
  endtask

  initial begin
    n_chk = 0; n_bad = 0;
    clear_in();
    rst_n = 0;
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1;
    t_clean_and_idle();
    t_l4();
    t_ip();
    t_crc();
    t_len();
    t_multi();
    t_hovf();
    @(negedge clk);
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule